// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block drives two, three or four buck power stages from one free-running switching-period counter. Every phase gets the same duty demand, trimmed by its own current-balance term. A phase whose sampled current sits above the mean of all fitted phases gets a shorter pulse. A phase below the mean gets a longer one. The fitted phases are spread evenly over one switching period, so the ripple the stages produce is interleaved.

The number of fitted phases comes from strap inputs that the board holds high on unused outputs. These straps are read once, on the first clock after reset is released, and are then held. Each output has an output-enable. Unused phases, reset and a low enable all leave the outputs undriven (high impedance at the pad). A per-phase strobe tells the current-sense front end when to take its sample. It comes one third of a switching period after that phase's high pulse ends.

Top module: `mphase_pwm`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, every `pwm`, `pwm_oe` and `smp_stb` bit is low.
- R2: The straps are sampled on the first clock after reset release. `strap[3]`=0 selects four phases. `strap[3]`=1 with `strap[2]`=1 selects two. `strap[3]`=1 with `strap[2]`=0 selects three. Later strap changes have no effect until the next reset.
- R3: Channels at index N or above (N = phase count) keep `pwm_oe` and `pwm` low.
- R4: With N phases, channel k's period starts k*PERIOD/N clocks (integer division) after channel 0's, seen as the spacing between their rising `pwm` edges.
- R5: Each active channel stays high for D clocks per period. D = demand - (I_k - M), where I_k is that channel's current and M = floor(sum of active currents / N). The balance shift is 0.
- R6: The currents of inactive channels affect neither M nor any duty.
- R7: D is clamped to the range 0 to PERIOD-2.
- R8: With `enable` low, every `pwm_oe` and `pwm` bit goes low on the next clock and stays low. Normal duty returns once `enable` is high again.
- R9: `smp_stb[k]` is a one-clock pulse. It rises PERIOD/3 clocks after each falling edge of `pwm[k]`.
- R10: `pwm[k]` is never high while `pwm_oe[k]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter run; low forces all outputs undriven |
| demand | input | CNT_W | Duty demand in clocks per period |
| isense | input | MAX_PH*CUR_W | Sampled current per channel, channel k at bits k*CUR_W |
| strap | input | MAX_PH | Phase-presence straps, high marks an unused channel |
| pwm | output | MAX_PH | PWM drive per channel |
| pwm_oe | output | MAX_PH | Output-enable per channel; low means high impedance |
| smp_stb | output | MAX_PH | Current-sample strobe per channel |

## Verification
The assertions assume that `enable` and the straps are synchronous to `clk`. They also assume that `demand` and `isense` may change at any clock, because a duty word is only captured at the start of its own channel's period. The stimulus changes inputs only at falling clock edges. After every change to demand or currents it waits two full periods, so each channel has loaded a settled duty word before any pulse is measured. The phase count is changed only through a fresh reset with new strap values. A strap change during operation is applied only to show that it is ignored.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

   typedef enum logic [1:0] {
      MODE_4PH = 2'd0,
      MODE_3PH = 2'd1,
      MODE_2PH = 2'd2
   } ph_mode_e;

   function automatic logic [2:0] mode_count(ph_mode_e m);
      case (m)
         MODE_2PH: return 3'd2;
         MODE_3PH: return 3'd3;
         default:  return 3'd4;
      endcase
   endfunction

   // last strap high means fewer than four phases; the one before it
   // then tells two from three
   function automatic ph_mode_e decode_straps(logic hi_last, logic hi_prev);
      if (!hi_last)     return MODE_4PH;
      else if (hi_prev) return MODE_2PH;
      else              return MODE_3PH;
   endfunction

endpackage

// File: rtl/mpp_phase_detect.sv
module mpp_phase_detect
   import mpp_pkg::*;
#(
   parameter int MAX_PH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MAX_PH-1:0] strap_i,
   output ph_mode_e          mode_o,
   output logic [2:0]        count_o,
   output logic              ready_o
);

   ph_mode_e mode_q;
   logic     ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_4PH;
         ready_q <= 1'b0;
      end else if (!ready_q) begin
         mode_q  <= decode_straps(strap_i[MAX_PH-1], strap_i[MAX_PH-2]);
         ready_q <= 1'b1;
      end
   end

   assign mode_o  = mode_q;
   assign ready_o = ready_q;
   assign count_o = mode_count(mode_q);

   assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> (ready_q && $stable(mode_q)));

endmodule

// File: rtl/mpp_period_ctr.sv
module mpp_period_ctr #(
   parameter int CNT_W  = 10,
   parameter int PERIOD = 120
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/mpp_balance.sv
module mpp_balance #(
   parameter int MAX_PH    = 4,
   parameter int CUR_W     = 8,
   parameter int BAL_SHIFT = 0,
   localparam int SUM_W    = CUR_W + 2,
   localparam int CORR_W   = CUR_W + 3
) (
   input  logic [MAX_PH*CUR_W-1:0]  isense_i,
   input  logic [2:0]               count_i,
   output logic [MAX_PH*CORR_W-1:0] corr_o
);

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] mean;

   // only channels below the phase count contribute to the mean
   always_comb begin
      sum = '0;
      for (int k = 0; k < MAX_PH; k++) begin
         if (3'(k) < count_i) sum = sum + SUM_W'(isense_i[k*CUR_W +: CUR_W]);
      end
   end

   always_comb begin
      case (count_i)
         3'd2:    mean = sum >> 1;
         3'd3:    mean = sum / SUM_W'(3);
         default: mean = sum >> 2;
      endcase
   end

   for (genvar g = 0; g < MAX_PH; g++) begin : g_corr
      logic signed [CORR_W-1:0] diff;
      assign diff = $signed({3'b000, isense_i[g*CUR_W +: CUR_W]})
                  - $signed({1'b0, mean});
      assign corr_o[g*CORR_W +: CORR_W] = diff >>> BAL_SHIFT;
   end

endmodule

// File: rtl/mpp_channel.sv
module mpp_channel #(
   parameter int IDX     = 0,
   parameter int CNT_W   = 10,
   parameter int PERIOD  = 120,
   parameter int CORR_W  = 11,
   parameter int SMP_DLY = 40
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable_i,
   input  logic                     ready_i,
   input  logic [2:0]               count_i,
   input  logic [CNT_W-1:0]         cnt_i,
   input  logic [CNT_W-1:0]         demand_i,
   input  logic signed [CORR_W-1:0] corr_i,
   output logic                     pwm_o,
   output logic                     oe_o,
   output logic                     smp_o
);

   localparam int TW = ((CNT_W > CORR_W) ? CNT_W : CORR_W) + 2;
   localparam logic [CNT_W-1:0] OFF2 = CNT_W'(((IDX * PERIOD) / 2) % PERIOD);
   localparam logic [CNT_W-1:0] OFF3 = CNT_W'(((IDX * PERIOD) / 3) % PERIOD);
   localparam logic [CNT_W-1:0] OFF4 = CNT_W'(((IDX * PERIOD) / 4) % PERIOD);
   localparam logic [CNT_W-1:0] PER  = CNT_W'(PERIOD);
   localparam logic [CNT_W-1:0] DMAX = CNT_W'(PERIOD - 2);
   localparam logic signed [TW-1:0] DMAX_S = TW'(PERIOD - 2);

   logic             act;
   logic             go;
   logic [CNT_W-1:0] off;
   logic [CNT_W-1:0] loc;
   logic signed [TW-1:0] tgt;
   logic [CNT_W-1:0] duty_new;
   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] duty_eff;
   logic [CNT_W-1:0] tmr_q;
   logic             pwm_q;
   logic             oe_q;
   logic             smp_q;

   assign act = (3'(IDX) < count_i);
   assign go  = ready_i && enable_i && act;

   always_comb begin
      case (count_i)
         3'd2:    off = OFF2;
         3'd3:    off = OFF3;
         default: off = OFF4;
      endcase
   end

   // position of this channel inside its own switching period
   always_comb begin
      if (cnt_i >= off) loc = cnt_i - off;
      else              loc = cnt_i + (PER - off);
   end

   // demand minus the balance term, clamped to keep an off-time
   always_comb begin
      tgt = $signed({{(TW-CNT_W){1'b0}}, demand_i}) - TW'(corr_i);
      if (tgt < 0)           duty_new = '0;
      else if (tgt > DMAX_S) duty_new = DMAX;
      else                   duty_new = tgt[CNT_W-1:0];
   end

   assign duty_eff = (loc == '0) ? duty_new : duty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_q <= '0;
         pwm_q  <= 1'b0;
         oe_q   <= 1'b0;
         tmr_q  <= '0;
         smp_q  <= 1'b0;
      end else begin
         if (ready_i && loc == '0) duty_q <= duty_eff;
         pwm_q <= go && (loc < duty_eff);
         oe_q  <= go;
         if (!go)                  tmr_q <= '0;
         else if (loc == duty_eff) tmr_q <= CNT_W'(SMP_DLY);
         else if (tmr_q != '0)     tmr_q <= tmr_q - 1'b1;
         smp_q <= go && (tmr_q == CNT_W'(1));
      end
   end

   assign pwm_o = pwm_q;
   assign oe_o  = oe_q;
   assign smp_o = smp_q;

   assert_duty_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      duty_q <= DMAX);
   assert_pwm_needs_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_q |-> oe_q);
   assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (!oe_q && !pwm_q));
   assert_idle_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_i && !act) |=> !oe_q);
   assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_q |=> !smp_q);

endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
   import mpp_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int PERIOD    = 120,
   parameter int MAX_PH    = 4,
   parameter int CUR_W     = 8,
   parameter int BAL_SHIFT = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic [CNT_W-1:0]        demand,
   input  logic [MAX_PH*CUR_W-1:0] isense,
   input  logic [MAX_PH-1:0]       strap,
   output logic [MAX_PH-1:0]       pwm,
   output logic [MAX_PH-1:0]       pwm_oe,
   output logic [MAX_PH-1:0]       smp_stb
);

   localparam int CORR_W  = CUR_W + 3;
   localparam int SMP_DLY = PERIOD / 3;

   if (PERIOD > (1 << CNT_W)) begin : g_chk_period
      $error("PERIOD does not fit the period counter");
   end
   if (PERIOD < 12) begin : g_chk_min
      $error("PERIOD too short for sampling delay");
   end
   if (MAX_PH != 4) begin : g_chk_ph
      $error("strap decoding expects four channels");
   end

   ph_mode_e                 mode;
   logic [2:0]               count;
   logic                     ready;
   logic [CNT_W-1:0]         cnt;
   logic [MAX_PH*CORR_W-1:0] corr;

   mpp_phase_detect #(.MAX_PH(MAX_PH)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap),
      .mode_o  (mode),
      .count_o (count),
      .ready_o (ready)
   );

   mpp_period_ctr #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (ready),
      .cnt_o (cnt)
   );

   mpp_balance #(.MAX_PH(MAX_PH), .CUR_W(CUR_W), .BAL_SHIFT(BAL_SHIFT)) u_bal (
      .isense_i (isense),
      .count_i  (count),
      .corr_o   (corr)
   );

   for (genvar g = 0; g < MAX_PH; g++) begin : g_ch
      mpp_channel #(
         .IDX     (g),
         .CNT_W   (CNT_W),
         .PERIOD  (PERIOD),
         .CORR_W  (CORR_W),
         .SMP_DLY (SMP_DLY)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .enable_i (enable),
         .ready_i  (ready),
         .count_i  (count),
         .cnt_i    (cnt),
         .demand_i (demand),
         .corr_i   ($signed(corr[g*CORR_W +: CORR_W])),
         .pwm_o    (pwm[g]),
         .oe_o     (pwm_oe[g]),
         .smp_o    (smp_stb[g])
      );
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (pwm_oe == '0 && pwm == '0 && smp_stb == '0));

endmodule

// File: tb/mphase_pwm_tb.sv
module mphase_pwm_tb;

   localparam int CNT_W  = 10;
   localparam int PERIOD = 120;
   localparam int NPH    = 4;
   localparam int CUR_W  = 8;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   enable = 1'b0;
   logic [CNT_W-1:0]       demand = '0;
   logic [NPH*CUR_W-1:0]   isense = '0;
   logic [NPH-1:0]         strap = '0;
   logic [NPH-1:0]         pwm, pwm_oe, smp_stb;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mphase_pwm #(.CNT_W(CNT_W), .PERIOD(PERIOD), .MAX_PH(NPH), .CUR_W(CUR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .demand(demand),
      .isense(isense), .strap(strap), .pwm(pwm), .pwm_oe(pwm_oe), .smp_stb(smp_stb)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cur(int c0, int c1, int c2, int c3);
      isense = {CUR_W'(c3), CUR_W'(c2), CUR_W'(c1), CUR_W'(c0)};
   endtask

   task automatic do_reset(logic [NPH-1:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      wait_cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic high_count(int ch, output int n);
      n = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         if (pwm[ch]) n++;
      end
   endtask

   task automatic rise_time(int ch, output longint t);
      logic prev;
      t = -1;
      @(negedge clk);
      prev = pwm[ch];
      for (int i = 0; i < 3*PERIOD; i++) begin
         @(negedge clk);
         if (!prev && pwm[ch]) begin
            t = longint'($time / 10);
            break;
         end
         prev = pwm[ch];
      end
   endtask

   task automatic check_offsets(string req, int n);
      longint t0, tk;
      for (int k = 1; k < n; k++) begin
         rise_time(0, t0);
         rise_time(k, tk);
         check(req, int'((tk - t0) % PERIOD), (k * PERIOD) / n);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      rst_n = 1'b0;
      enable = 1'b1;
      strap = 4'b0000;
      wait_cycles(3);
      check("R1 oe in reset", int'(pwm_oe), 0);
      check("R1 pwm in reset", int'(pwm), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 oe first cycle after reset", int'(pwm_oe), 0);
      check("R1 strobe first cycle after reset", int'(smp_stb), 0);
   endtask

   task automatic test_four_phase();
      int n;
      demand = 10'd50;
      set_cur(30, 30, 30, 30);
      do_reset(4'b0000);
      wait_cycles(2*PERIOD);
      check("R2 four-phase oe", int'(pwm_oe), 4'b1111);
      for (int k = 0; k < 4; k++) begin
         high_count(k, n);
         check("R5 equal currents duty", n, 50);
      end
      check_offsets("R4 four-phase offset", 4);
   endtask

   task automatic test_three_phase();
      int n;
      demand = 10'd50;
      set_cur(30, 30, 30, 0);
      do_reset(4'b1000);
      wait_cycles(2*PERIOD);
      check("R2 three-phase oe", int'(pwm_oe), 4'b0111);
      high_count(3, n);
      check("R3 unused channel pwm", n, 0);
      check_offsets("R4 three-phase offset", 3);
      set_cur(30, 30, 30, 200);
      wait_cycles(2*PERIOD);
      high_count(0, n);
      check("R6 inactive current ignored", n, 50);
   endtask

   task automatic test_two_phase();
      demand = 10'd40;
      set_cur(30, 30, 0, 0);
      do_reset(4'b1100);
      wait_cycles(2*PERIOD);
      check("R2 two-phase oe", int'(pwm_oe), 4'b0011);
      check_offsets("R4 two-phase offset", 2);
      strap = 4'b0000;
      wait_cycles(2*PERIOD);
      check("R2 strap change ignored", int'(pwm_oe), 4'b0011);
   endtask

   task automatic test_balance();
      int n;
      demand = 10'd50;
      set_cur(40, 20, 30, 30);
      do_reset(4'b0000);
      wait_cycles(2*PERIOD);
      high_count(0, n);
      check("R5 above mean shortened", n, 40);
      high_count(1, n);
      check("R5 below mean lengthened", n, 60);
      high_count(2, n);
      check("R5 at mean unchanged", n, 50);
   endtask

   task automatic test_clamp();
      int n;
      demand = 10'd200;
      set_cur(30, 30, 30, 30);
      wait_cycles(2*PERIOD);
      high_count(0, n);
      check("R7 clamp high", n, PERIOD - 2);
      demand = 10'd5;
      set_cur(90, 30, 30, 30);
      wait_cycles(2*PERIOD);
      high_count(0, n);
      check("R7 clamp low", n, 0);
      high_count(1, n);
      check("R5 small demand plus correction", n, 20);
   endtask

   task automatic test_enable();
      int bad_oe, bad_pwm, n;
      demand = 10'd50;
      set_cur(30, 30, 30, 30);
      wait_cycles(2*PERIOD);
      enable = 1'b0;
      @(negedge clk);
      check("R8 oe drops next cycle", int'(pwm_oe), 0);
      bad_oe = 0;
      bad_pwm = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         if (pwm_oe != '0) bad_oe++;
         if ((pwm & ~pwm_oe) != '0) bad_pwm++;
      end
      check("R8 oe held low", bad_oe, 0);
      check("R10 pwm without oe", bad_pwm, 0);
      enable = 1'b1;
      wait_cycles(2*PERIOD);
      high_count(2, n);
      check("R8 duty after re-enable", n, 50);
   endtask

   task automatic test_strobe();
      longint tf, ts;
      logic prev;
      int width;
      tf = -1;
      ts = -1;
      @(negedge clk);
      prev = pwm[0];
      for (int i = 0; i < 2*PERIOD; i++) begin
         @(negedge clk);
         if (prev && !pwm[0]) begin
            tf = longint'($time / 10);
            break;
         end
         prev = pwm[0];
      end
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         if (smp_stb[0]) begin
            ts = longint'($time / 10);
            break;
         end
      end
      check("R9 strobe delay", int'(ts - tf), PERIOD / 3);
      width = 0;
      while (smp_stb[0] && width < 10) begin
         width++;
         @(negedge clk);
      end
      check("R9 strobe width", width, 1);
   endtask

   initial begin
      test_reset();
      test_four_phase();
      test_three_phase();
      test_two_phase();
      test_balance();
      test_clamp();
      test_enable();
      test_strobe();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(10 * 150000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule